// File: doc/BRIEF.md
# External Bus Strobe Generator

This block turns internal memory requests from a CPU into the control strobes of a multiplexed external memory bus. A request carries a direction, an address, a byte-or-word size and a flag that tells whether the target lies in on-chip memory. For external targets the block runs an address phase with an address latch pulse and then a data phase with the read or write strobes. It adds programmable wait clocks, stretches the data phase while the ready input is low, and decodes five active-low chip selects from the address bank.

A width-select input chooses a 16-bit or an 8-bit external data bus. The choice changes how the two byte-lane write enables are driven. In 16-bit mode the lanes follow address parity. In 8-bit mode only the low lane strobe is used, and word transfers that do not fit in one bus cycle are split into two byte cycles. Internal accesses always behave as 16-bit and take a single clock. An option can keep the strobes inactive during internal accesses. A hold request releases the bus between transfers and is answered on an acknowledge output.

The width, wait and strobe-mask settings are sampled when a request is accepted. Changing them during a transfer does not affect that transfer.

Top module: `xbus_strobe_gen`

## Requirements
- R1: The width-select input `byte_mode_i` at 0 selects a 16-bit external bus and at 1 selects an 8-bit external bus. The value is sampled when a request is accepted.
- R2: In 16-bit mode a byte write to an even address (bit 0 = 0) drives `wel_n` low only. A byte write to an odd address drives `weh_n` low only. A word write to an even address drives both low in the same data clocks.
- R3: In 8-bit mode every external write drives `wel_n` low and keeps `weh_n` high. An external word access in 8-bit mode, or a word access to an odd address in 16-bit mode, runs as two byte cycles: the first at the given address and the second at that address plus one, each with its own address phase.
- R4: During the data clocks of a read, `rd_n` is low and both write enables are high. During a write, `rd_n` stays high.
- R5: Each external bus cycle starts with exactly one clock in which `ale` is high, all strobes are high and `bus_addr_o` carries the cycle address. The data phase begins in the following clock.
- R6: With `wait_off_i` = 1 the data phase lasts one clock. With `wait_off_i` = 0 it lasts two clocks when `wait_sel_i` = 0 and three clocks when `wait_sel_i` = 1, provided that ready stays high.
- R7: The data phase cannot end on a clock edge at which `ready_n_i` is low. It is extended clock by clock until ready is sampled high with no wait clocks left.
- R8: When `hold_n_i` is low while the block is idle, `hlda_n` goes low at the next clock. While `hlda_n` is low, all strobes are high, `ale` is low, all chip selects are high and requests are ignored. `hlda_n` returns high at the clock after `hold_n_i` rises.
- R9: During the address and data phases of an external access, `cs_n[i]` is low exactly when address bits [19:16] equal i+1 (banks 1 to 5). Accesses to any other bank assert no chip select.
- R10: An internal access takes one strobe clock with no `ale` and no chip select. Its lanes follow the 16-bit rules of R2 whatever the width select, and wait settings and ready are ignored.
- R11: When `strobe_mask_int_i` = 1, an internal access leaves `rd_n`, `wel_n` and `weh_n` high. The option has no effect on external accesses.
- R12: `req_done` is high for exactly one clock, the clock after the last data clock of a request. `req_ready` is high only while the block is idle and `hold_n_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_internal | input | 1 | Target is on-chip memory |
| req_addr | input | 20 | Byte address |
| req_done | output | 1 | One-clock completion pulse |
| byte_mode_i | input | 1 | External width select: 0 = 16-bit, 1 = 8-bit |
| wait_off_i | input | 1 | 1 = no wait clocks, 0 = insert wait clocks |
| wait_sel_i | input | 1 | Wait length: 0 = one clock, 1 = two clocks |
| strobe_mask_int_i | input | 1 | Keep strobes high on internal accesses |
| ready_n_i | input | 1 | Ready, low stalls the data phase |
| hold_n_i | input | 1 | Bus hold request, active low |
| hlda_n | output | 1 | Hold acknowledge, active low |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read enable, active low |
| wel_n | output | 1 | Low-lane write enable, active low |
| weh_n | output | 1 | High-lane write enable, active low |
| cs_n | output | 5 | Chip selects, active low |
| bus_addr_o | output | 20 | Address of the current bus cycle |

## Verification
A request is accepted at a rising edge. The address phase (`ale`, chip select, address) is visible in the clock that follows. The first data clock comes one clock later, and `req_done` appears one clock after the final data clock. An internal access shows its strobe in the first clock after acceptance and `req_done` in the second. The hold acknowledge follows `hold_n_i` by one clock. The bench drives inputs and samples outputs on falling edges. For each access it walks clock by clock from acceptance to `req_done`, counting address pulses and data clocks and recording the strobes and chip selects it sees, so every result is compared in the clock in which it is due.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_INT  = 3'd4
    } xbs_state_e;

    // active-low strobe bundle
    typedef struct packed {
        logic rd_n;
        logic wl_n;
        logic wh_n;
    } xbs_lanes_t;

endpackage

// File: rtl/xbs_cs_decode.sv
module xbs_cs_decode #(
    parameter int PG_W      = 4,
    parameter int NUM_CS    = 5,
    parameter int BASE_PAGE = 1
) (
    input  logic [PG_W-1:0]   page_i,
    input  logic              en_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        localparam logic [PG_W-1:0] MY_PAGE = PG_W'(BASE_PAGE + gi);
        assign cs_n_o[gi] = !(en_i && (page_i == MY_PAGE));
    end

endmodule

// File: rtl/xbs_lane_sel.sv
module xbs_lane_sel
    import xbs_pkg::*;
(
    input  logic       active_i,
    input  logic       write_i,
    input  logic       word_i,
    input  logic       a0_i,
    input  logic       narrow_i,
    output xbs_lanes_t lanes_o
);

    always_comb begin
        lanes_o = '{rd_n: 1'b1, wl_n: 1'b1, wh_n: 1'b1};
        if (active_i) begin
            if (!write_i) begin
                lanes_o.rd_n = 1'b0;
            end else if (narrow_i) begin
                lanes_o.wl_n = 1'b0;
            end else if (word_i) begin
                lanes_o.wl_n = 1'b0;
                lanes_o.wh_n = 1'b0;
            end else if (a0_i) begin
                lanes_o.wh_n = 1'b0;
            end else begin
                lanes_o.wl_n = 1'b0;
            end
        end
    end

endmodule

// File: rtl/xbs_wait_calc.sv
module xbs_wait_calc #(
    parameter int WAIT_SHORT = 1,
    parameter int WAIT_LONG  = 2,
    parameter int WCNT_W     = 2
) (
    input  logic              wait_off_i,
    input  logic              wait_sel_i,
    output logic [WCNT_W-1:0] wait_o
);

    always_comb begin
        if (wait_off_i)      wait_o = '0;
        else if (wait_sel_i) wait_o = WCNT_W'(WAIT_LONG);
        else                 wait_o = WCNT_W'(WAIT_SHORT);
    end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbs_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int NUM_CS     = 5,
    parameter int PAGE_BITS  = 16,
    parameter int BASE_PAGE  = 1,
    parameter int WAIT_SHORT = 1,
    parameter int WAIT_LONG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_internal,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_done,
    input  logic              byte_mode_i,
    input  logic              wait_off_i,
    input  logic              wait_sel_i,
    input  logic              strobe_mask_int_i,
    input  logic              ready_n_i,
    input  logic              hold_n_i,
    output logic              hlda_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wel_n,
    output logic              weh_n,
    output logic [NUM_CS-1:0] cs_n,
    output logic [ADDR_W-1:0] bus_addr_o
);

    localparam int WCNT_W = $clog2(WAIT_LONG + 1);
    localparam int PG_W   = ADDR_W - PAGE_BITS;

    typedef struct packed {
        xbs_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              word;
        logic              ext;
        logic              narrow;
        logic              mask;
        logic              split;
        logic [WCNT_W-1:0] wload;
        logic [WCNT_W-1:0] wcnt;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [WCNT_W-1:0] wait_new;
    logic              split_new;
    logic              strobe_act;
    logic              cs_en;
    xbs_lanes_t        lanes;

    xbs_wait_calc #(
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG),
        .WCNT_W     (WCNT_W)
    ) u_wait (
        .wait_off_i (wait_off_i),
        .wait_sel_i (wait_sel_i),
        .wait_o     (wait_new)
    );

    // a word that needs two byte cycles on the external bus
    assign split_new = !req_internal && req_word && (byte_mode_i || req_addr[0]);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (!hold_n_i) begin
                    seq_d.st = ST_HOLD;
                end else if (req_valid) begin
                    seq_d.addr   = req_addr;
                    seq_d.write  = req_write;
                    seq_d.ext    = !req_internal;
                    seq_d.narrow = byte_mode_i && !req_internal;
                    seq_d.mask   = strobe_mask_int_i;
                    seq_d.split  = split_new;
                    seq_d.word   = req_word && !split_new;
                    seq_d.wload  = wait_new;
                    seq_d.st     = req_internal ? ST_INT : ST_ADDR;
                end
            end
            ST_HOLD: begin
                if (hold_n_i) seq_d.st = ST_IDLE;
            end
            ST_ADDR: begin
                seq_d.st   = ST_DATA;
                seq_d.wcnt = seq_q.wload;
            end
            ST_DATA: begin
                if (seq_q.wcnt != '0) begin
                    seq_d.wcnt = seq_q.wcnt - WCNT_W'(1);
                end else if (ready_n_i) begin
                    if (seq_q.split) begin
                        seq_d.split = 1'b0;
                        seq_d.addr  = seq_q.addr + ADDR_W'(1);
                        seq_d.st    = ST_ADDR;
                    end else begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_INT: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign strobe_act = (seq_q.st == ST_DATA) || ((seq_q.st == ST_INT) && !seq_q.mask);
    assign cs_en      = (seq_q.st == ST_ADDR) || (seq_q.st == ST_DATA);

    xbs_lane_sel u_lanes (
        .active_i (strobe_act),
        .write_i  (seq_q.write),
        .word_i   (seq_q.word),
        .a0_i     (seq_q.addr[0]),
        .narrow_i (seq_q.narrow),
        .lanes_o  (lanes)
    );

    xbs_cs_decode #(
        .PG_W      (PG_W),
        .NUM_CS    (NUM_CS),
        .BASE_PAGE (BASE_PAGE)
    ) u_cs (
        .page_i (seq_q.addr[ADDR_W-1:PAGE_BITS]),
        .en_i   (cs_en),
        .cs_n_o (cs_n)
    );

    assign rd_n       = lanes.rd_n;
    assign wel_n      = lanes.wl_n;
    assign weh_n      = lanes.wh_n;
    assign ale        = (seq_q.st == ST_ADDR);
    assign hlda_n     = (seq_q.st != ST_HOLD);
    assign req_ready  = (seq_q.st == ST_IDLE) && hold_n_i;
    assign req_done   = seq_q.done;
    assign bus_addr_o = seq_q.addr;

endmodule

// File: rtl/xbs_strobe_chk.sv
module xbs_strobe_chk #(
    parameter int NUM_CS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic              rd_n,
    input logic              wel_n,
    input logic              weh_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              hlda_n,
    input logic              hold_n_i,
    input logic              req_done,
    input logic              narrow_ext
);

    // R5
    ale_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R5
    ale_quiet_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wel_n && weh_n));

    // R4
    rd_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (wel_n && weh_n));

    // R3
    narrow_high_lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_ext |-> weh_n);

    // R9
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R8
    hold_released_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hlda_n |-> (rd_n && wel_n && weh_n && !ale && (&cs_n)));

    // R8
    hold_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda_n) |-> $past(!hold_n_i));

    // R12
    done_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

endmodule

bind xbus_strobe_gen xbs_strobe_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale        (ale),
    .rd_n       (rd_n),
    .wel_n      (wel_n),
    .weh_n      (weh_n),
    .cs_n       (cs_n),
    .hlda_n     (hlda_n),
    .hold_n_i   (hold_n_i),
    .req_done   (req_done),
    .narrow_ext (seq_q.ext && seq_q.narrow)
);

// File: tb/sim_xbus_strobe_gen.sv
module sim_xbus_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic        req_internal = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_done;
    logic        byte_mode_i = 1'b0;
    logic        wait_off_i = 1'b1;
    logic        wait_sel_i = 1'b0;
    logic        strobe_mask_int_i = 1'b0;
    logic        ready_n_i = 1'b1;
    logic        hold_n_i = 1'b1;
    logic        hlda_n, ale, rd_n, wel_n, weh_n;
    logic [4:0]  cs_n;
    logic [19:0] bus_addr_o;

    int errors = 0;
    int checks = 0;

    // measurements of the last access
    int          m_ale, m_data;
    logic        m_rd, m_wl, m_wh, m_done;
    logic [19:0] m_addr1, m_addr2;
    logic [4:0]  m_cs_ale, m_cs_all;

    always #5 clk = ~clk;

    xbus_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_internal(req_internal),
        .req_addr(req_addr), .req_done(req_done), .byte_mode_i(byte_mode_i),
        .wait_off_i(wait_off_i), .wait_sel_i(wait_sel_i),
        .strobe_mask_int_i(strobe_mask_int_i), .ready_n_i(ready_n_i),
        .hold_n_i(hold_n_i), .hlda_n(hlda_n), .ale(ale), .rd_n(rd_n),
        .wel_n(wel_n), .weh_n(weh_n), .cs_n(cs_n), .bus_addr_o(bus_addr_o)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input logic wr, input logic [19:0] a, input logic wd,
                              input logic intern, input int stall);
        int i;
        m_ale = 0; m_data = 0; m_rd = 0; m_wl = 0; m_wh = 0; m_done = 0;
        m_addr1 = '0; m_addr2 = '0; m_cs_ale = '1; m_cs_all = '1;
        for (int k = 0; k < 20 && !req_ready; k++) @(negedge clk);
        ready_n_i    = (stall > 0) ? 1'b0 : 1'b1;
        req_write    = wr;
        req_addr     = a;
        req_word     = wd;
        req_internal = intern;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        i = 0;
        while (i < 60) begin
            i++;
            if (ale) begin
                m_ale++;
                if (m_ale == 1) begin m_addr1 = bus_addr_o; m_cs_ale = cs_n; end
                else m_addr2 = bus_addr_o;
            end
            m_cs_all = m_cs_all & cs_n;
            if (!rd_n || !wel_n || !weh_n) m_data++;
            if (!rd_n)  m_rd = 1'b1;
            if (!wel_n) m_wl = 1'b1;
            if (!weh_n) m_wh = 1'b1;
            if (req_done) begin
                m_done = 1'b1;
                break;
            end
            if (i == stall + 1) ready_n_i = 1'b1;
            @(negedge clk);
        end
        ready_n_i = 1'b1;
    endtask

    task automatic t_reset;
        chk(rd_n && wel_n && weh_n, "R4 reset strobes", {rd_n, wel_n, weh_n}, 3'b111);
        chk(!ale && cs_n == 5'h1f && hlda_n, "R5 reset ale/cs/hlda", {ale, cs_n, hlda_n}, 7'b0111111);
        chk(req_ready && !req_done, "R12 reset ready/done", {req_ready, req_done}, 2'b10);
    endtask

    task automatic t_wide_lanes;
        byte_mode_i = 1'b0; wait_off_i = 1'b1;
        run_access(1'b1, 20'h1_0010, 1'b0, 1'b0, 0);
        chk(m_wl && !m_wh && !m_rd, "R2 even byte lanes", {m_rd, m_wl, m_wh}, 3'b010);
        chk(m_ale == 1 && m_addr1 == 20'h1_0010, "R5 ale once with address", m_addr1, 20'h1_0010);
        chk(m_data == 1, "R6 no-wait data clocks", m_data, 1);
        run_access(1'b1, 20'h1_0011, 1'b0, 1'b0, 0);
        chk(!m_wl && m_wh, "R2 odd byte lanes", {m_wl, m_wh}, 2'b01);
        run_access(1'b1, 20'h1_0020, 1'b1, 1'b0, 0);
        chk(m_wl && m_wh && m_ale == 1 && m_data == 1, "R2 even word one cycle",
            {m_wl, m_wh, 4'(m_ale), 4'(m_data)}, {2'b11, 4'd1, 4'd1});
        run_access(1'b1, 20'h1_0031, 1'b1, 1'b0, 0);
        chk(m_ale == 2 && m_addr2 == 20'h1_0032, "R3 odd word split in wide mode", m_addr2, 20'h1_0032);
    endtask

    task automatic t_narrow;
        byte_mode_i = 1'b1;
        run_access(1'b1, 20'h2_0041, 1'b0, 1'b0, 0);
        chk(m_wl && !m_wh, "R1 R3 narrow odd byte uses low lane", {m_wl, m_wh}, 2'b10);
        run_access(1'b1, 20'h2_0050, 1'b1, 1'b0, 0);
        chk(m_ale == 2 && m_data == 2, "R3 narrow word two cycles", {4'(m_ale), 4'(m_data)}, 8'h22);
        chk(m_addr1 == 20'h2_0050 && m_addr2 == 20'h2_0051, "R3 narrow word addresses", m_addr2, 20'h2_0051);
        chk(m_wl && !m_wh, "R3 narrow word lanes", {m_wl, m_wh}, 2'b10);
        byte_mode_i = 1'b0;
    endtask

    task automatic t_read;
        run_access(1'b0, 20'h1_0100, 1'b1, 1'b0, 0);
        chk(m_rd && !m_wl && !m_wh, "R4 read strobe only", {m_rd, m_wl, m_wh}, 3'b100);
    endtask

    task automatic t_waits;
        wait_off_i = 1'b0; wait_sel_i = 1'b0;
        run_access(1'b0, 20'h1_0200, 1'b0, 1'b0, 0);
        chk(m_data == 2, "R6 short wait", m_data, 2);
        wait_sel_i = 1'b1;
        run_access(1'b0, 20'h1_0200, 1'b0, 1'b0, 0);
        chk(m_data == 3, "R6 long wait", m_data, 3);
        wait_off_i = 1'b1;
    endtask

    task automatic t_ready;
        run_access(1'b1, 20'h1_0300, 1'b0, 1'b0, 3);
        chk(m_data == 3 && m_done, "R7 ready stall", m_data, 3);
    endtask

    task automatic t_cs;
        run_access(1'b0, 20'h3_0010, 1'b0, 1'b0, 0);
        chk(m_cs_ale == 5'b11011 && m_cs_all == 5'b11011, "R9 bank 3 select", m_cs_all, 5'b11011);
        run_access(1'b0, 20'h0_8000, 1'b0, 1'b0, 0);
        chk(m_cs_all == 5'b11111, "R9 bank 0 no select", m_cs_all, 5'b11111);
        run_access(1'b0, 20'h5_0000, 1'b0, 1'b0, 0);
        chk(m_cs_all == 5'b01111, "R9 bank 5 select", m_cs_all, 5'b01111);
    endtask

    task automatic t_internal;
        byte_mode_i = 1'b1; wait_off_i = 1'b0; wait_sel_i = 1'b1;
        run_access(1'b1, 20'h0_0101, 1'b0, 1'b1, 3);
        chk(m_ale == 0 && m_data == 1 && m_cs_all == 5'h1f, "R10 internal single clock",
            {4'(m_ale), 4'(m_data), m_cs_all}, {4'd0, 4'd1, 5'h1f});
        chk(!m_wl && m_wh, "R10 internal wide lanes", {m_wl, m_wh}, 2'b01);
        byte_mode_i = 1'b0; wait_off_i = 1'b1; wait_sel_i = 1'b0;
    endtask

    task automatic t_mask;
        strobe_mask_int_i = 1'b1;
        run_access(1'b1, 20'h0_0200, 1'b1, 1'b1, 0);
        chk(m_data == 0 && m_done, "R11 internal strobes masked", m_data, 0);
        run_access(1'b1, 20'h1_0200, 1'b1, 1'b0, 0);
        chk(m_data == 1 && m_wl && m_wh, "R11 external unaffected", m_data, 1);
        strobe_mask_int_i = 1'b0;
    endtask

    task automatic t_done;
        run_access(1'b0, 20'h1_0400, 1'b0, 1'b0, 0);
        chk(m_done && req_ready, "R12 done with ready", {m_done, req_ready}, 2'b11);
        @(negedge clk);
        chk(!req_done, "R12 done one clock", req_done, 0);
    endtask

    task automatic t_hold;
        logic seen;
        seen = 1'b0;
        @(negedge clk);
        hold_n_i  = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_internal = 1'b0;
        req_addr  = 20'h1_0000; req_word = 1'b0;
        @(negedge clk);
        chk(!hlda_n && !req_ready, "R8 hold ack", {hlda_n, req_ready}, 2'b00);
        for (int k = 0; k < 3; k++) begin
            if (ale || !wel_n || !rd_n || cs_n != 5'h1f) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R8 request ignored in hold", seen, 0);
        req_valid = 1'b0;
        hold_n_i  = 1'b1;
        @(negedge clk);
        chk(hlda_n && !ale, "R8 hold release", {hlda_n, ale}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_lanes();
        t_narrow();
        t_read();
        t_waits();
        t_ready();
        t_cs();
        t_internal();
        t_mask();
        t_done();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule